// File: doc/BRIEF.md
# Audio Clock and Processor Clock Sequencer

This block makes the sample-rate clocks for the audio converters and the clock and reset of a control processor. It uses two clock inputs. One is an audio reference running at 256 times the sample rate, for example 11.2896 MHz for 44.1 kHz. The other is a master clock from a PLL at four times the reference. The converter clocks (256FS, 64FS and FS) come from the reference. They are phase aligned, so the FS and 64FS outputs change on the same reference edge. The processor clock is the master clock divided by five, which gives about 9.03 MHz with the nominal reference.

A free-running fallback oscillator clocks the processor during reset, and the processor is held in reset while that clock is in use. After system initialization reports done, the block switches the processor clock to the divided master clock. The switch is break-before-make: the old source is gated off on its falling edge, and the new source is enabled only after two synchronizing edges of its own clock. The processor reset is released a programmable number of processor cycles after the switch completes, so the processor always has a running clock while it leaves reset.

Top module: `audio_cpu_clkseq`

## Requirements
- R1: `fs256_clk` is a copy of `ref_clk` at all times.
- R2: While `rst_n` is low, `fs64_clk` and `fs_clk` are 0. After reset, `fs64_clk` toggles every 2 rising edges of `ref_clk`, giving a period of 4 reference cycles at 50 % duty. `fs_clk` toggles every 128 rising edges, giving a period of 256 reference cycles at 50 % duty.
- R3: Every change of `fs_clk` happens on the same rising edge of `ref_clk` as a change of `fs64_clk`.
- R4: Once the processor runs from the master source, `cpu_clk` has a period of 5 `pll_clk` cycles and is high for 2 of them.
- R5: `cpu_clk` follows `osc_clk` from reset until the switch. The two sources are never enabled together. `cpu_clk` never produces a pulse shorter than 2 `pll_clk` periods or half an `osc_clk` period, whichever is shorter.
- R6: `cpu_rst_n` goes to 0 at once when `rst_n` goes low. It stays 0 for as long as `init_done` has not been taken and whenever the master source is not driving `cpu_clk`.
- R7: `cpu_rst_n` rises on rising edge number RST_HOLD+2 of the master-derived `cpu_clk`. The count includes the first such edge and covers 2 synchronizer edges plus RST_HOLD hold cycles. The default is edge 18.
- R8: `init_done` is sticky. Once it has been taken, a later drop of `init_done` is ignored until the next `rst_n` assertion, and `cpu_rst_n` stays 1.
- R9: A new assertion of `rst_n` returns `cpu_clk` to `osc_clk`. If `init_done` is high when `rst_n` is released, the whole sequence runs again and ends with the same R7 edge count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pll_clk | input | 1 | Master clock, 4x the reference |
| ref_clk | input | 1 | Audio reference clock (256FS) |
| osc_clk | input | 1 | Free-running fallback oscillator |
| rst_n | input | 1 | Asynchronous active-low system reset |
| init_done | input | 1 | System initialization complete (level) |
| fs_clk | output | 1 | Sample-rate clock, reference/256 |
| fs64_clk | output | 1 | Bit clock, reference/4 |
| fs256_clk | output | 1 | Oversampling clock, equal to reference |
| cpu_clk | output | 1 | Processor clock |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
The bench times every `cpu_clk` edge. It would catch a mux that enables the new source before the old one is gated, or one that cuts a phase, because either fault leaves a short pulse or a both-sources window. It counts the run of evenly spaced master edges that ends at reset release, so a synchronizer stage too few or too many, or an off-by-one in the hold counter, shows up as a wrong count (expected 18). It measures how far apart the FS and 64FS toggles are, and whether they coincide, in reference edges. A divider with the wrong tap, or with outputs taken from different counter states, breaks the 2/128 spacing or the alignment. It then drops `init_done` after release and later re-enters reset with `init_done` already high. A non-sticky request would glitch the processor back into reset, and a sequencer that is not restartable would never release it.

// File: rtl/clkseq_pkg.sv
`timescale 1ns/1ps
package clkseq_pkg;
  localparam int unsigned DOM_OSC = 0;
  localparam int unsigned DOM_PLL = 1;
  localparam int unsigned DOM_REF = 2;
  localparam int unsigned N_DOM   = 3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_OSC  = 2'b01,
    SRC_MST  = 2'b10,
    SRC_BOTH = 2'b11
  } cpu_src_e;
endpackage

// File: rtl/clkseq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer with selectable reset value; also used as a
// reset synchronizer (d tied high, reset value 0).
module clkseq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clkseq_audio_div.sv
`timescale 1ns/1ps
// One free-running counter on the reference; both outputs are counter bits,
// so every toggle of the slower bit lands on a toggle of the faster bit.
module clkseq_audio_div #(
  parameter int unsigned FS64_DIV = 4,
  parameter int unsigned FS_DIV   = 256
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic fs64_clk,
  output logic fs_clk
);
  localparam int unsigned CW  = $clog2(FS_DIV);
  localparam int unsigned B64 = $clog2(FS64_DIV) - 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + CW'(1);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fs64_clk = cnt_q[B64];
  assign fs_clk   = cnt_q[CW-1];
endmodule

// File: rtl/clkseq_mst_div.sv
`timescale 1ns/1ps
// Integer divider of the master clock with a registered output:
// high for DIV/2 cycles, low for the rest.
module clkseq_mst_div #(
  parameter int unsigned DIV = 5
) (
  input  logic pll_clk,
  input  logic rst_n,
  output logic div_clk
);
  localparam int unsigned CW   = $clog2(DIV);
  localparam int unsigned HIGH = DIV / 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clk_q, clk_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    clk_d = (cnt_d < CW'(HIGH));
  end

  always_ff @(posedge pll_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LAST;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign div_clk = clk_q;
endmodule

// File: rtl/clkseq_glitchfree_mux.sv
`timescale 1ns/1ps
// Break-before-make two-input clock switch. Each side requests when the
// other side is off, synchronizes on its own clock, and changes its enable
// on its own falling edge.
module clkseq_glitchfree_mux #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic mst_clk,
  input  logic osc_rst_n,
  input  logic mst_rst_n,
  input  logic sel_mst,
  output logic cpu_clk,
  output logic osc_en,
  output logic mst_en
);
  logic osc_req, osc_req_s;
  logic mst_req, mst_req_s;

  always_comb begin
    osc_req = ~sel_mst & ~mst_en;
    mst_req =  sel_mst & ~osc_en;
  end

  clkseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_osc_sync (
    .clk(osc_clk), .arst_n(osc_rst_n), .d(osc_req), .q(osc_req_s));

  clkseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mst_sync (
    .clk(mst_clk), .arst_n(mst_rst_n), .d(mst_req), .q(mst_req_s));

  always_ff @(negedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) osc_en <= 1'b1;
    else            osc_en <= osc_req_s;
  end

  always_ff @(negedge mst_clk or negedge mst_rst_n) begin
    if (!mst_rst_n) mst_en <= 1'b0;
    else            mst_en <= mst_req_s;
  end

  assign cpu_clk = (osc_clk & osc_en) | (mst_clk & mst_en);
endmodule

// File: rtl/clkseq_start_ctl.sv
`timescale 1ns/1ps
// Takes init_done (sticky) in the master-divided domain and releases the
// processor reset RST_HOLD cycles after the switch is seen on cpu_clk.
module clkseq_start_ctl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_HOLD    = 16
) (
  input  logic mst_clk,
  input  logic cpu_clk,
  input  logic rst_n,
  input  logic init_done,
  input  logic mst_en,
  output logic sel_mst,
  output logic cpu_rst_n
);
  localparam int unsigned HW = $clog2(RST_HOLD + 1);
  localparam logic [HW-1:0] HOLD_MAX  = HW'(RST_HOLD);
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD - 1);

  logic init_s, sel_d;
  logic sw_done;
  logic [HW-1:0] cnt_q, cnt_d;
  logic rel_d;

  clkseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_init_sync (
    .clk(mst_clk), .arst_n(rst_n), .d(init_done), .q(init_s));

  always_comb sel_d = sel_mst | init_s;

  always_ff @(posedge mst_clk or negedge rst_n) begin
    if (!rst_n) sel_mst <= 1'b0;
    else        sel_mst <= sel_d;
  end

  clkseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
    .clk(cpu_clk), .arst_n(rst_n), .d(mst_en), .q(sw_done));

  always_comb begin
    if (!sw_done)               cnt_d = '0;
    else if (cnt_q == HOLD_MAX) cnt_d = cnt_q;
    else                        cnt_d = cnt_q + HW'(1);
    rel_d = sw_done & (cnt_q >= HOLD_LAST);
  end

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cpu_rst_n <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      cpu_rst_n <= rel_d;
    end
  end
endmodule

// File: rtl/audio_cpu_clkseq.sv
`timescale 1ns/1ps
module audio_cpu_clkseq
  import clkseq_pkg::*;
#(
  parameter int unsigned MST_DIV     = 5,
  parameter int unsigned FS64_DIV    = 4,
  parameter int unsigned FS_DIV      = 256,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned RST_HOLD    = 16
) (
  input  logic pll_clk,
  input  logic ref_clk,
  input  logic osc_clk,
  input  logic rst_n,
  input  logic init_done,
  output logic fs_clk,
  output logic fs64_clk,
  output logic fs256_clk,
  output logic cpu_clk,
  output logic cpu_rst_n
);
  logic [N_DOM-1:0] dom_clk, dom_rst_n;
  logic mst_div_clk, sel_mst, osc_en, mst_en;
  cpu_src_e cpu_src;

  assign dom_clk[DOM_OSC] = osc_clk;
  assign dom_clk[DOM_PLL] = pll_clk;
  assign dom_clk[DOM_REF] = ref_clk;

  // asynchronous assertion, release aligned to each domain's clock
  for (genvar g = 0; g < N_DOM; g++) begin : g_rst
    clkseq_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
      .clk(dom_clk[g]), .arst_n(rst_n), .d(1'b1), .q(dom_rst_n[g]));
  end

  assign fs256_clk = ref_clk;

  clkseq_audio_div #(.FS64_DIV(FS64_DIV), .FS_DIV(FS_DIV)) u_audio_div (
    .ref_clk(ref_clk), .rst_n(dom_rst_n[DOM_REF]),
    .fs64_clk(fs64_clk), .fs_clk(fs_clk));

  clkseq_mst_div #(.DIV(MST_DIV)) u_mst_div (
    .pll_clk(pll_clk), .rst_n(dom_rst_n[DOM_PLL]), .div_clk(mst_div_clk));

  clkseq_glitchfree_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .osc_clk(osc_clk), .mst_clk(mst_div_clk),
    .osc_rst_n(dom_rst_n[DOM_OSC]), .mst_rst_n(dom_rst_n[DOM_PLL]),
    .sel_mst(sel_mst), .cpu_clk(cpu_clk),
    .osc_en(osc_en), .mst_en(mst_en));

  clkseq_start_ctl #(.SYNC_STAGES(SYNC_STAGES), .RST_HOLD(RST_HOLD)) u_start (
    .mst_clk(mst_div_clk), .cpu_clk(cpu_clk), .rst_n(dom_rst_n[DOM_PLL]),
    .init_done(init_done), .mst_en(mst_en),
    .sel_mst(sel_mst), .cpu_rst_n(cpu_rst_n));

  assign cpu_src = cpu_src_e'({mst_en, osc_en});
endmodule

// File: rtl/clkseq_chk.sv
`timescale 1ns/1ps
module clkseq_chk
  import clkseq_pkg::*;
(
  input logic     pll_clk,
  input logic     ref_clk,
  input logic     rst_n,
  input logic     fs_clk,
  input logic     fs64_clk,
  input logic     div_clk,
  input cpu_src_e cpu_src,
  input logic     mst_en,
  input logic     cpu_rst_n
);
  assert_one_source_R5: assert property (@(posedge pll_clk) disable iff (!rst_n)
    cpu_src != SRC_BOTH);

  assert_rst_needs_mst_R6: assert property (@(posedge pll_clk) disable iff (!rst_n)
    cpu_rst_n |-> mst_en);

  assert_rst_sticky_R8: assert property (@(posedge pll_clk) disable iff (!rst_n)
    cpu_rst_n |=> cpu_rst_n);

  assert_fs_aligned_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(fs_clk) |-> !$stable(fs64_clk));

  assert_div_high_R4: assert property (@(posedge pll_clk) disable iff (!rst_n)
    $rose(div_clk) |=> div_clk);

  assert_div_low_R4: assert property (@(posedge pll_clk) disable iff (!rst_n)
    $fell(div_clk) |=> !div_clk);
endmodule

bind audio_cpu_clkseq clkseq_chk u_chk (
  .pll_clk(pll_clk), .ref_clk(ref_clk), .rst_n(rst_n),
  .fs_clk(fs_clk), .fs64_clk(fs64_clk), .div_clk(mst_div_clk),
  .cpu_src(cpu_src), .mst_en(mst_en), .cpu_rst_n(cpu_rst_n));

// File: tb/test_audio_cpu_clkseq.sv
`timescale 1ns/1ps
module test_audio_cpu_clkseq;
  localparam int HOLD   = 16;
  localparam int EXP_RUN = HOLD + 2;

  logic pll_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic [1:0] pcnt = 2'd0;
  logic ref_clk;
  logic rst_n, init_done;
  logic fs_clk, fs64_clk, fs256_clk, cpu_clk, cpu_rst_n;

  int nchk = 0, nfail = 0;

  always #2.5 pll_clk = ~pll_clk;
  always #17  osc_clk = ~osc_clk;
  always @(posedge pll_clk) pcnt <= pcnt + 2'd1;
  assign ref_clk = pcnt[1];

  audio_cpu_clkseq #(.RST_HOLD(HOLD)) i_audio_cpu_clkseq (
    .pll_clk(pll_clk), .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n),
    .init_done(init_done), .fs_clk(fs_clk), .fs64_clk(fs64_clk),
    .fs256_clk(fs256_clk), .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // processor clock edge monitors
  bit  mon_cpu = 0;
  real t_rise = 0.0, t_edge = 0.0;
  int  run = 0, glitches = 0, r4_err = 0, r4_n = 0;
  bit  rel_seen = 0;
  int  rel_run = 0;

  always @(cpu_clk) begin
    if (mon_cpu) begin
      if (t_edge > 0.0 && ($realtime - t_edge) < 9.99) glitches++;
      t_edge = $realtime;
    end else t_edge = 0.0;
  end

  always @(posedge cpu_clk) begin
    real gap;
    gap = $realtime - t_rise;
    if (mon_cpu && t_rise > 0.0 && gap > 24.99 && gap < 25.01) run++;
    else run = 1;
    if (mon_cpu && cpu_rst_n) begin
      r4_n++;
      if (!(gap > 24.99 && gap < 25.01)) r4_err++;
    end
    t_rise = $realtime;
  end

  always @(negedge cpu_clk) begin
    real hi;
    hi = $realtime - t_rise;
    if (mon_cpu && cpu_rst_n && !(hi > 9.99 && hi < 10.01)) r4_err++;
    if (!rel_seen && cpu_rst_n) begin
      rel_seen = 1;
      rel_run  = run;
    end
  end

  // audio clock monitor, sampled at reference falling edges
  bit mon_aud = 0;
  int idx = 0, last64 = -1, lastfs = -1, n64 = 0, nfs = 0;
  int e64 = 0, efs = 0, ealign = 0;
  logic p64 = 1'b0, pfs = 1'b0;

  always @(negedge ref_clk) begin
    if (mon_aud) begin
      idx++;
      if (fs64_clk != p64) begin
        if (last64 >= 0 && idx - last64 != 2) e64++;
        last64 = idx; n64++;
      end
      if (fs_clk != pfs) begin
        if (fs64_clk == p64) ealign++;
        if (lastfs >= 0 && idx - lastfs != 128) efs++;
        lastfs = idx; nfs++;
      end
    end else begin
      last64 = -1; lastfs = -1;
    end
    p64 = fs64_clk; pfs = fs_clk;
  end

  task automatic sample_osc(input int n, input string tag);
    int bad = 0, bad256 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge pll_clk);
      if (cpu_clk != osc_clk) bad++;
      if (fs256_clk != ref_clk) bad256++;
    end
    chk(bad == 0, tag, bad, 0);
    chk(bad256 == 0, "R1 fs256 equals reference", bad256, 0);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 4000 && !rel_seen; i++) @(negedge pll_clk);
  endtask

  initial begin
    #200000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int bad;
    rst_n = 1'b0; init_done = 1'b0;
    #100;
    chk(cpu_rst_n == 1'b0, "R6 reset cpu_rst_n", int'(cpu_rst_n), 0);
    chk(fs_clk == 1'b0 && fs64_clk == 1'b0, "R2 audio clocks low in reset",
        int'({fs_clk, fs64_clk}), 0);
    sample_osc(20, "R5 cpu_clk follows osc in reset");

    @(negedge pll_clk); rst_n = 1'b1;
    mon_aud = 1; mon_cpu = 1;
    bad = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge pll_clk);
      if (cpu_rst_n) bad++;
    end
    chk(bad == 0, "R6 held in reset before init_done", bad, 0);
    sample_osc(40, "R5 cpu_clk follows osc before init_done");

    @(negedge pll_clk); init_done = 1'b1; rel_seen = 0;
    wait_release();
    chk(rel_seen, "R7 reset released", int'(rel_seen), 1);
    chk(rel_run == EXP_RUN, "R7 master edges up to release", rel_run, EXP_RUN);

    repeat (200) @(negedge pll_clk);
    init_done = 1'b0;
    bad = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge pll_clk);
      if (!cpu_rst_n) bad++;
    end
    chk(bad == 0, "R8 init_done drop ignored", bad, 0);

    repeat (12000) @(negedge pll_clk);
    chk(n64 > 100 && e64 == 0, "R2 fs64 toggles every 2 ref edges", e64, 0);
    chk(nfs >= 3 && efs == 0, "R2 fs toggles every 128 ref edges", nfs >= 3 ? efs : -1, 0);
    chk(ealign == 0, "R3 fs changes with fs64", ealign, 0);
    chk(r4_n > 100 && r4_err == 0, "R4 master cpu_clk 5 periods high 2", r4_err, 0);

    mon_cpu = 0; mon_aud = 0;
    @(negedge pll_clk); #0.7 rst_n = 1'b0;
    @(negedge pll_clk);
    chk(cpu_rst_n == 1'b0, "R9 reassert drives cpu_rst_n low", int'(cpu_rst_n), 0);
    chk(fs_clk == 1'b0 && fs64_clk == 1'b0, "R2 audio clocks cleared",
        int'({fs_clk, fs64_clk}), 0);
    init_done = 1'b1;
    sample_osc(20, "R9 cpu_clk back on osc in reset");

    @(negedge pll_clk); rst_n = 1'b1; mon_cpu = 1; rel_seen = 0;
    wait_release();
    chk(rel_seen && rel_run == EXP_RUN, "R9 second sequence edge count",
        rel_run, EXP_RUN);
    repeat (100) @(negedge pll_clk);
    chk(glitches == 0, "R5 no short cpu_clk pulse", glitches, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule